// File: doc/BRIEF.md
# Flash Sector Program Sequencer

This block lets a host write one whole sector of a byte-wide parallel flash device. The host asks for a write by pulsing `start` with a sector number. The block then pulls exactly one sector's worth of bytes, 128 by default, from a valid/ready stream. For each byte it performs one write strobe on the flash pins, with setup, pulse-width and hold lengths set in clock cycles. The address bus carries the sector number in the upper bits and the byte index in the lower bits.

The flash stops accepting bytes and begins its internal programming as soon as too long passes between two write strobes. The block therefore limits how long it waits for the next byte. If the stream runs dry past a margin kept below the device timeout, the block gives up and raises an error flag, so that a partial sector is never reported as success. After the final byte it reads the device repeatedly. Each read compares the top data bit with the top bit of the last byte written. The write is complete when the two agree, or it fails when a cycle limit on polling runs out.

Top module: `flash_sector_writer`

## Requirements
- R1: While in reset and after it, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe` is low, and `busy`, `in_ready` and `done` are low.
- R2: `start` is taken only while `busy` is low. A `start` seen while busy has no effect: every later strobe of the running write still carries the first sector number.
- R3: Each strobe drives `fl_addr[15:7]` with the sector number and `fl_addr[6:0]` with the byte index. The indices run 0 to 127 in order, one write strobe per byte.
- R4: Throughout each strobe, `fl_ce_n` is low and `fl_oe_n` is high. `fl_ce_n` falls with `fl_dq_oe` high for exactly SETUP_CYC cycles before `fl_we_n` falls. `fl_we_n` stays low for PULSE_CYC cycles. `fl_dq_oe` and the data stay for HOLD_CYC cycles after `fl_we_n` rises. Address and data stay stable while `fl_we_n` is low.
- R5: The byte on `fl_dq_out` during a strobe is the byte accepted for that index. `fl_dq_oe` is high only inside a strobe window.
- R6: `in_ready` is high only while busy and waiting for the next byte. A byte is taken on a cycle with `in_valid` and `in_ready` both high. `in_valid` while idle causes no strobe.
- R7: Once the first byte is in, if `in_valid` stays low for STALL_LIMIT consecutive waiting cycles, the write aborts with no further strobe. A wait of STALL_LIMIT-1 cycles is still accepted. The wait before the first byte is unlimited. STALL_LIMIT is LOAD_GAP_CYC-GAP_MARGIN-HOLD_CYC-SETUP_CYC, which is 53 by default. An abort sets `err_starve` and pulses `done`.
- R8: Between a rising edge of `fl_we_n` and the next falling edge in the same sector, `fl_we_n` is high for at most LOAD_GAP_CYC-GAP_MARGIN cycles.
- R9: After the last byte the block polls. During polling `fl_ce_n` and `fl_oe_n` are low, `fl_we_n` is high and `fl_dq_oe` is low. It samples `fl_dq_msb_in` after every READ_CYC cycles of a read. It ends without error at the first sample equal to bit 7 of the last byte.
- R10: If no sample matches, the block ends after exactly POLL_MAX cycles with `fl_oe_n` low, sets `err_timeout` and pulses `done`.
- R11: `busy` is high from an accepted start until the write ends. `done` is a one-cycle pulse at the end. The error flags hold until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to write a sector |
| start_sector | input | 9 | Sector number for the request |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when a write ends |
| err_starve | output | 1 | Last write aborted because the stream stalled |
| err_timeout | output | 1 | Last write's completion poll ran out |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| fl_addr | output | 16 | Flash address: sector and byte index |
| fl_dq_out | output | 8 | Data to the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_msb_in | input | 1 | Top data bit read back from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The assertions assume that the flash only drives `fl_dq_msb_in` meaningfully while `fl_oe_n` is low. They also assume that `in_valid` is held until it is taken. The bench meets both conditions. Its device model drives the inverted top bit until a set delay after the last strobe. Its stream task raises `in_valid` only after it sees `in_ready` and drops it on the edge that takes the byte. Stalls are placed at exact offsets from `in_ready` rising, so the cases one cycle below and exactly at the stall limit are both exercised.

// File: rtl/flash_sector_writer.sv
module flash_sector_writer #(
  parameter int SECT_W       = 9,
  parameter int IDX_W        = 7,
  parameter int DATA_W       = 8,
  parameter int SETUP_CYC    = 2,
  parameter int PULSE_CYC    = 3,
  parameter int HOLD_CYC     = 1,
  parameter int READ_CYC     = 2,
  parameter int LOAD_GAP_CYC = 64,
  parameter int GAP_MARGIN   = 8,
  parameter int POLL_MAX     = 400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SECT_W-1:0]        start_sector,
  output logic                     busy,
  output logic                     done,
  output logic                     err_starve,
  output logic                     err_timeout,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     in_ready,
  output logic [SECT_W+IDX_W-1:0]  fl_addr,
  output logic [DATA_W-1:0]        fl_dq_out,
  output logic                     fl_dq_oe,
  input  logic                     fl_dq_msb_in,
  output logic                     fl_ce_n,
  output logic                     fl_we_n,
  output logic                     fl_oe_n
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ADDR_W      = SECT_W + IDX_W;
  localparam int LAST_IDX    = (1 << IDX_W) - 1;
  localparam int GAP_BOUND   = LOAD_GAP_CYC - GAP_MARGIN;
  localparam int STALL_LIMIT = GAP_BOUND - HOLD_CYC - SETUP_CYC;
  localparam int PH_MAX      = imax(imax(SETUP_CYC, PULSE_CYC), imax(imax(HOLD_CYC, READ_CYC), STALL_LIMIT));
  localparam int PH_W        = $clog2(PH_MAX + 1);
  localparam int PL_W        = $clog2(POLL_MAX + 1);
  localparam int GAP_W       = $clog2(GAP_BOUND + 2) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SETUP, S_PULSE, S_HOLD, S_POLL} state_t;

  state_t              st;
  logic [SECT_W-1:0]   sect_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DATA_W-1:0]   data_q;
  logic [PH_W-1:0]     ph_cnt;
  logic [PL_W-1:0]     poll_cnt;
  logic                done_q, starve_q, tmo_q;

  wire setup_end = ph_cnt == PH_W'(SETUP_CYC - 1);
  wire pulse_end = ph_cnt == PH_W'(PULSE_CYC - 1);
  wire hold_end  = ph_cnt == PH_W'(HOLD_CYC - 1);
  wire read_end  = ph_cnt == PH_W'(READ_CYC - 1);
  wire stall_end = ph_cnt == PH_W'(STALL_LIMIT - 1);
  wire last_byte = idx_q == IDX_W'(LAST_IDX);
  wire poll_hit  = read_end && (fl_dq_msb_in == data_q[DATA_W-1]);
  wire poll_out  = poll_cnt == PL_W'(POLL_MAX - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sect_q   <= '0;
      idx_q    <= '0;
      data_q   <= '0;
      ph_cnt   <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      starve_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            sect_q   <= start_sector;
            idx_q    <= '0;
            ph_cnt   <= '0;
            starve_q <= 1'b0;
            tmo_q    <= 1'b0;
            st       <= S_WAIT;
          end
        S_WAIT:
          if (in_valid) begin
            data_q <= in_data;
            ph_cnt <= '0;
            st     <= S_SETUP;
          end else if (idx_q != '0) begin
            if (stall_end) begin
              starve_q <= 1'b1;
              done_q   <= 1'b1;
              st       <= S_IDLE;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
        S_SETUP:
          if (setup_end) begin
            ph_cnt <= '0;
            st     <= S_PULSE;
          end else ph_cnt <= ph_cnt + 1'b1;
        S_PULSE:
          if (pulse_end) begin
            ph_cnt <= '0;
            st     <= S_HOLD;
          end else ph_cnt <= ph_cnt + 1'b1;
        S_HOLD:
          if (hold_end) begin
            ph_cnt <= '0;
            if (last_byte) begin
              poll_cnt <= '0;
              st       <= S_POLL;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= S_WAIT;
            end
          end else ph_cnt <= ph_cnt + 1'b1;
        S_POLL: begin
          poll_cnt <= poll_cnt + 1'b1;
          ph_cnt   <= read_end ? '0 : ph_cnt + 1'b1;
          if (poll_hit) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (poll_out) begin
            tmo_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire loading = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);

  assign busy        = st != S_IDLE;
  assign done        = done_q;
  assign err_starve  = starve_q;
  assign err_timeout = tmo_q;
  assign in_ready    = st == S_WAIT;
  assign fl_addr     = {sect_q, idx_q};
  assign fl_dq_out   = data_q;
  assign fl_dq_oe    = loading;
  assign fl_ce_n     = !(loading || st == S_POLL);
  assign fl_we_n     = st != S_PULSE;
  assign fl_oe_n     = st != S_POLL;

  logic [GAP_W-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) gap_cnt <= '0;
    else if (!fl_we_n) gap_cnt <= '0;
    else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !in_ready); // R1
  AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_addr[ADDR_W-1:IDX_W])); // R2
  AST_WE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n && fl_oe_n && fl_dq_oe); // R4
  AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr) && $stable(fl_dq_out)); // R4
  AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> fl_dq_oe && !fl_ce_n && $stable(fl_dq_out)); // R5
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy && fl_we_n); // R6
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) && fl_addr[IDX_W-1:0] != '0) |-> gap_cnt <= GAP_W'(GAP_BOUND)); // R8
  AST_POLL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> fl_we_n && !fl_dq_oe && !fl_ce_n); // R9
  AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_starve && err_timeout)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

endmodule

// File: tb/flash_sector_writer_bench.sv
`timescale 1ns/1ps
module flash_sector_writer_bench;
  localparam int SETUP = 2, PULSE = 3, HOLD = 1, READ = 2;
  localparam int LOAD_GAP = 64, MARGIN = 8, POLL_MAX = 400;
  localparam int GAP_BOUND = LOAD_GAP - MARGIN;
  localparam int STALL = GAP_BOUND - HOLD - SETUP;

  logic clk = 0, rst_n = 0;
  logic start = 0; logic [8:0] start_sector = '0;
  logic busy, done, err_starve, err_timeout;
  logic in_valid = 0; logic [7:0] in_data = '0; logic in_ready;
  logic [15:0] fl_addr; logic [7:0] fl_dq_out; logic fl_dq_oe;
  logic fl_dq_msb_in; logic fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  flash_sector_writer #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD), .READ_CYC(READ),
    .LOAD_GAP_CYC(LOAD_GAP), .GAP_MARGIN(MARGIN), .POLL_MAX(POLL_MAX)) u_flash_sector_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_sector(start_sector), .busy(busy), .done(done),
    .err_starve(err_starve), .err_timeout(err_timeout), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_msb_in(fl_dq_msb_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * seed + 53) ^ (i << 3));
  endfunction

  logic [7:0] mem [0:127];
  int loads, exp_idx, bad_sector, setup_run, pulse_run, hold_run, gap_run, oe_low_run, post_cnt;
  int poll_delay;
  logic [8:0] exp_sector;
  logic [7:0] last_exp, fall_dq;
  logic [15:0] fall_addr;
  logic status_ok = 0, in_hold = 0, prev_we = 1;

  assign fl_dq_msb_in = status_ok ? last_exp[7] : ~last_exp[7];

  always @(negedge clk) if (rst_n) begin
    if (!fl_dq_oe) setup_run = 0;
    else if (!fl_ce_n && fl_we_n && !in_hold) setup_run++;
    if (prev_we && !fl_we_n) begin
      chk(setup_run == SETUP, "R4 setup", setup_run, SETUP);
      chk(!fl_ce_n && fl_oe_n, "R4 strobe frame", {fl_ce_n, fl_oe_n}, 2'b01);
      chk(fl_addr == {exp_sector, 7'(exp_idx)}, "R3 address", fl_addr, {exp_sector, 7'(exp_idx)});
      if (fl_addr[15:7] != exp_sector) bad_sector++;
      if (exp_idx > 0) chk(gap_run <= GAP_BOUND, "R8 gap", gap_run, GAP_BOUND);
      fall_addr = fl_addr; fall_dq = fl_dq_out; pulse_run = 1;
    end else if (!fl_we_n) begin
      pulse_run++;
      chk(fl_addr == fall_addr && fl_dq_out == fall_dq, "R4 stable", fl_addr, fall_addr);
    end
    if (!prev_we && fl_we_n) begin
      chk(pulse_run == PULSE, "R4 pulse", pulse_run, PULSE);
      mem[fl_addr[6:0]] = fl_dq_out;
      loads++; exp_idx++;
      hold_run = 1; in_hold = 1; gap_run = 1;
    end else begin
      if (fl_we_n) gap_run++;
      if (in_hold) begin
        if (fl_dq_oe) hold_run++;
        else begin
          chk(hold_run == HOLD, "R4 hold", hold_run, HOLD);
          in_hold = 0;
        end
      end
    end
    if (fl_dq_oe) chk(!fl_ce_n && fl_oe_n, "R5 drive window", {fl_ce_n, fl_oe_n}, 2'b01);
    if (in_ready && !busy) chk(0, "R6 ready while idle", in_ready, 0);
    if (!fl_oe_n) begin
      oe_low_run++;
      chk(!fl_ce_n && fl_we_n && !fl_dq_oe, "R9 poll bus", {fl_ce_n, fl_we_n, fl_dq_oe}, 3'b010);
    end
    if (loads == 128) post_cnt++;
    status_ok = (poll_delay >= 0) && (loads == 128) && (post_cnt >= poll_delay);
    prev_we = fl_we_n;
  end

  task automatic do_start(input logic [8:0] sector, input int seed, input int delay);
    @(negedge clk);
    exp_sector = sector; exp_idx = 0; loads = 0; bad_sector = 0; oe_low_run = 0;
    post_cnt = 0; poll_delay = delay; status_ok = 0; last_exp = pat(127, seed);
    start = 1; start_sector = sector;
    @(negedge clk);
    start = 0;
  endtask

  task automatic stream(input int seed, input int stall_idx, input int stall_len,
                        input int first_delay, output bit aborted);
    aborted = 0;
    repeat (first_delay) @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      int guard = 0;
      while (!in_ready) begin
        if (!busy || guard > 5000) begin aborted = 1; return; end
        @(negedge clk); guard++;
      end
      if (i == stall_idx) begin
        repeat (stall_len) @(posedge clk);
        @(negedge clk);
        if (!busy) begin aborted = 1; return; end
      end
      in_valid = 1; in_data = pat(i, seed);
      @(posedge clk); @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic wait_done(input int limit, output bit seen);
    seen = 0;
    for (int c = 0; c < limit; c++) begin
      if (done) begin seen = 1; return; end
      @(negedge clk);
    end
  endtask

  function automatic int mem_mismatch(input int seed, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[i] != pat(i, seed)) bad++;
    return bad;
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 strobes in reset",
        {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !in_ready && !done && fl_ce_n && fl_we_n && fl_oe_n, "R1 idle after reset",
        {busy, in_ready, done}, 0);
  endtask

  task automatic t_normal;
    bit ab, seen;
    do_start(9'h1A5, 7, 20);
    chk(busy, "R11 busy after start", busy, 1);
    stream(7, -1, 0, 0, ab);
    chk(!ab, "R6 stream accepted", ab, 0);
    wait_done(2000, seen);
    chk(seen, "R11 done pulse", seen, 1);
    chk(status_ok, "R9 done only after status matches", status_ok, 1);
    chk(!err_starve && !err_timeout, "R9 clean finish", {err_starve, err_timeout}, 0);
    chk(oe_low_run % READ == 0 && oe_low_run > 0, "R9 read length", oe_low_run, READ);
    chk(loads == 128, "R3 one strobe per byte", loads, 128);
    chk(mem_mismatch(7, 128) == 0, "R5 data loaded", mem_mismatch(7, 128), 0);
    chk(!busy, "R11 idle at done", busy, 0);
    @(negedge clk);
    chk(!done, "R11 done single cycle", done, 0);
  endtask

  task automatic t_abort;
    bit ab, seen;
    do_start(9'h003, 11, 10);
    stream(11, 10, STALL, 0, ab);
    chk(ab, "R7 stall aborts", ab, 1);
    wait_done(10, seen);
    chk(seen && err_starve && !err_timeout, "R7 starve flag",
        {seen, err_starve, err_timeout}, 3'b110);
    chk(loads == 10, "R7 no strobe after stall", loads, 10);
    in_valid = 1; in_data = 8'hA5;
    repeat (100) @(negedge clk);
    in_valid = 0;
    chk(loads == 10 && !busy && !in_ready, "R6 valid while idle ignored", loads, 10);
    chk(err_starve, "R11 error flag holds", err_starve, 1);
  endtask

  task automatic t_stall_ok;
    bit ab, seen;
    do_start(9'h0F0, 5, 30);
    chk(!err_starve, "R11 start clears error", err_starve, 0);
    repeat (3) @(negedge clk);
    start = 1; start_sector = 9'h055;
    @(negedge clk);
    start = 0;
    stream(5, 50, STALL - 1, 200, ab);
    chk(!ab, "R7 stall below limit kept", ab, 1'b0);
    wait_done(2000, seen);
    chk(seen && !err_starve && !err_timeout, "R7 finish after long wait",
        {seen, err_starve, err_timeout}, 3'b100);
    chk(bad_sector == 0, "R2 start while busy ignored", bad_sector, 0);
    chk(loads == 128 && mem_mismatch(5, 128) == 0, "R5 data with stall", loads, 128);
  endtask

  task automatic t_timeout;
    bit ab, seen;
    do_start(9'h1FF, 3, -1);
    stream(3, -1, 0, 0, ab);
    wait_done(POLL_MAX + 100, seen);
    chk(seen && err_timeout && !err_starve, "R10 timeout flag",
        {seen, err_timeout, err_starve}, 3'b110);
    chk(oe_low_run == POLL_MAX, "R10 poll length", oe_low_run, POLL_MAX);
    chk(mem_mismatch(3, 128) == 0, "R5 data before timeout", mem_mismatch(3, 128), 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    poll_delay = -1; last_exp = '0; exp_sector = '0;
    repeat (4) @(posedge clk);
    t_reset;
    t_normal;
    t_abort;
    t_stall_ok;
    t_timeout;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule